// File: doc/BRIEF.md
# Horizontal Drive Start and Stop Sequencer

This block generates the line-rate horizontal drive pulse from a base clock that runs at a fixed multiple of the line frequency. The base clock is divided into lines of `LINE_TICKS` ticks, which is 432 by default. Every line also carries a reference pulse of fixed width at its start, whether or not the drive is running.

Around this divider sits the logic that keeps the output stage safe.

- **Oscillator control.** After reset the block asks the line oscillator to run fast (`freq_boost`). It drops that request only when a calibration request arrives after the crystal-indication register has been loaded. It then reports calibration in progress (`cal_busy`) until the frequency-reached flag is seen. A later out-of-lock report starts calibration again.
- **Shutdown latch.** Reset, an over-voltage trip and the standby bit all set a shutdown latch that holds the drive off. Only a host resume command clears it.
- **Duty ramp.** Each time the drive starts, its duty cycle begins at a small value and rises to its final value over `RAMP_LINES` lines. A fractional accumulator spreads the rounding evenly across those lines.

Top module: `hdrv_sequencer`

## Requirements
- R1: Lines repeat every `LINE_TICKS` base-clock ticks. `href` is high for exactly the first `REF_WIDTH` ticks of every line, independent of the drive state.
- R2: After reset, the outputs are as follows: `hdrv` = 0, `drive_on` = 0, `freq_boost` = 1, `cal_busy` = 0, `prot_flag` = 0. While `freq_boost` is 1 the drive never runs.
- R3: A `cal_req` pulse is accepted only if a `xtal_load` pulse occurred in an earlier cycle since reset. Otherwise it is ignored and `freq_boost` stays 1. An accepted request gives `freq_boost` = 0 and `cal_busy` = 1 one cycle later.
- R4: `cal_busy` falls one cycle after `freq_ok` is seen high during calibration. An `out_of_lock` pulse sets `cal_busy` one cycle later once the boost phase is over. While boosting, `out_of_lock` is ignored.
- R5: `ovp_trip` = 1 or `stby_n` = 0 turns the drive off one cycle later: `hdrv` = 0 and `drive_on` = 0. The drive stays off until a `resume_cmd` is accepted. A resume is accepted only with `stby_n` = 1 and no trip in the same cycle. Raising `stby_n` again does not restart the drive by itself.
- R6: `prot_flag` rises one cycle after `ovp_trip` and holds until an accepted `resume_cmd`. When a trip and a resume arrive in the same cycle, the trip wins. Standby alone never sets `prot_flag`.
- R7: The drive starts only at a line boundary. In the first running line, `hdrv` is high for `DUTY_START` ticks, starting at tick 0 of the line.
- R8: In running line j (j = 0 for the first line), `hdrv` is high for min(`DUTY_START` + floor((`DUTY_FINAL` − `DUTY_START`)·j / `RAMP_LINES`), `DUTY_FINAL`) contiguous ticks from tick 0. The value reaches `DUTY_FINAL` at j = `RAMP_LINES` and stays there.
- R9: Every restart after a shutdown begins the ramp again from `DUTY_START`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, `LINE_TICKS` ticks per line |
| rst | input | 1 | Synchronous active-high power-on reset |
| xtal_load | input | 1 | Pulse: crystal-indication register written |
| cal_req | input | 1 | Pulse: host requests oscillator calibration |
| freq_ok | input | 1 | Oscillator has reached nominal frequency |
| out_of_lock | input | 1 | Pulse: coincidence detector lost lock |
| stby_n | input | 1 | Standby control, 1 = normal, 0 = standby |
| ovp_trip | input | 1 | Over-voltage protection trip |
| resume_cmd | input | 1 | Pulse: host command returning to normal mode |
| hdrv | output | 1 | Horizontal drive pulse |
| href | output | 1 | Fixed-width line reference pulse |
| drive_on | output | 1 | Drive is running |
| freq_boost | output | 1 | Request for raised oscillator frequency |
| cal_busy | output | 1 | Calibration in progress |
| prot_flag | output | 1 | Latched over-voltage trip status |

## Verification
The collision that matters is a protection trip arriving in the same cycle as a host resume command. Both act on the shutdown latch and on the protection flag. The bench raises `ovp_trip` and `resume_cmd` together on a single edge, with the drive already stopped by an earlier trip. It then expects `prot_flag` to stay set and the next whole line to carry no drive pulse. A further collision is an out-of-lock report while the ramp is running: the bench expects `cal_busy` to rise while `drive_on` stays high.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

    typedef enum logic [1:0] {
        OSC_BOOST  = 2'd0,
        OSC_CAL    = 2'd1,
        OSC_LOCKED = 2'd2
    } osc_mode_e;

    localparam int DEF_LINE_TICKS = 432;
    localparam int DEF_REF_WIDTH  = 32;
    localparam int DEF_DUTY_START = 9;
    localparam int DEF_DUTY_FINAL = 238;
    localparam int DEF_RAMP_LINES = 300;

    function automatic int bits_for(input int n);
        return (n <= 1) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int ramp_span(input int lo, input int hi);
        return hi - lo;
    endfunction

endpackage

// File: rtl/hdrv_line_timer.sv
module hdrv_line_timer #(
    parameter int LINE_TICKS = 432,
    parameter int REF_WIDTH  = 32,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] tick_cnt,
    output logic             line_end,
    output logic             href
);

    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(LINE_TICKS - 1);
    localparam logic [CNT_W-1:0] REF_TICKS = CNT_W'(REF_WIDTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
        end else if (tick_cnt == LAST_TICK) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    assign line_end = (tick_cnt == LAST_TICK);
    assign href     = (tick_cnt < REF_TICKS);

endmodule

// File: rtl/hdrv_osc_ctrl.sv
module hdrv_osc_ctrl
    import hdrv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic xtal_load,
    input  logic cal_req,
    input  logic freq_ok,
    input  logic out_of_lock,
    output logic freq_boost,
    output logic cal_busy
);

    osc_mode_e mode_q;
    osc_mode_e mode_d;
    logic      xtal_seen_q;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            OSC_BOOST:  if (cal_req && xtal_seen_q) mode_d = OSC_CAL;
            OSC_CAL:    if (freq_ok)                mode_d = OSC_LOCKED;
            OSC_LOCKED: if (out_of_lock)            mode_d = OSC_CAL;
            default:                                mode_d = OSC_BOOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= OSC_BOOST;
            xtal_seen_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            if (xtal_load) xtal_seen_q <= 1'b1;
        end
    end

    assign freq_boost = (mode_q == OSC_BOOST);
    assign cal_busy   = (mode_q == OSC_CAL);

endmodule

// File: rtl/hdrv_guard.sv
module hdrv_guard (
    input  logic clk,
    input  logic rst,
    input  logic stby_n,
    input  logic ovp_trip,
    input  logic resume_cmd,
    output logic shut_q,
    output logic prot_flag
);

    logic resume_ok;

    assign resume_ok = resume_cmd && stby_n && !ovp_trip;

    always_ff @(posedge clk) begin
        if (rst) begin
            shut_q    <= 1'b1;
            prot_flag <= 1'b0;
        end else begin
            if (ovp_trip || !stby_n) shut_q <= 1'b1;
            else if (resume_ok)      shut_q <= 1'b0;

            if (ovp_trip)       prot_flag <= 1'b1;
            else if (resume_ok) prot_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/hdrv_ramp.sv
module hdrv_ramp
    import hdrv_pkg::*;
#(
    parameter int DUTY_START = 9,
    parameter int DUTY_FINAL = 238,
    parameter int RAMP_LINES = 300,
    parameter int CNT_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drive_ok,
    input  logic             line_end,
    input  logic [CNT_W-1:0] tick_cnt,
    output logic             run,
    output logic             hdrv
);

    localparam int SPAN  = ramp_span(DUTY_START, DUTY_FINAL);
    localparam int ACC_W = bits_for(RAMP_LINES + SPAN);

    localparam logic [CNT_W-1:0] D_START = CNT_W'(DUTY_START);
    localparam logic [CNT_W-1:0] D_FINAL = CNT_W'(DUTY_FINAL);
    localparam logic [ACC_W-1:0] A_SPAN  = ACC_W'(SPAN);
    localparam logic [ACC_W-1:0] A_LINES = ACC_W'(RAMP_LINES);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] duty;
        logic [ACC_W-1:0] acc;
    } ramp_state_t;

    ramp_state_t      st_q;
    ramp_state_t      st_d;
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = st_q.acc + A_SPAN;

    always_comb begin
        st_d = st_q;
        if (!drive_ok) begin
            st_d.run = 1'b0;
        end else if (line_end) begin
            if (!st_q.run) begin
                st_d.run  = 1'b1;
                st_d.duty = D_START;
                st_d.acc  = '0;
            end else if (st_q.duty < D_FINAL) begin
                if (acc_sum >= A_LINES) begin
                    st_d.acc  = acc_sum - A_LINES;
                    st_d.duty = st_q.duty + 1'b1;
                end else begin
                    st_d.acc = acc_sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.run  <= 1'b0;
            st_q.duty <= D_START;
            st_q.acc  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run  = st_q.run;
    assign hdrv = st_q.run && (tick_cnt < st_q.duty);

endmodule

// File: rtl/hdrv_sequencer.sv
module hdrv_sequencer
    import hdrv_pkg::*;
#(
    parameter int LINE_TICKS = DEF_LINE_TICKS,
    parameter int REF_WIDTH  = DEF_REF_WIDTH,
    parameter int DUTY_START = DEF_DUTY_START,
    parameter int DUTY_FINAL = DEF_DUTY_FINAL,
    parameter int RAMP_LINES = DEF_RAMP_LINES
) (
    input  logic clk,
    input  logic rst,
    input  logic xtal_load,
    input  logic cal_req,
    input  logic freq_ok,
    input  logic out_of_lock,
    input  logic stby_n,
    input  logic ovp_trip,
    input  logic resume_cmd,
    output logic hdrv,
    output logic href,
    output logic drive_on,
    output logic freq_boost,
    output logic cal_busy,
    output logic prot_flag
);

    localparam int CNT_W = bits_for(LINE_TICKS);

    logic [CNT_W-1:0] tick_cnt;
    logic             line_end;
    logic             shut_q;
    logic             drive_ok;

    hdrv_line_timer #(
        .LINE_TICKS(LINE_TICKS),
        .REF_WIDTH (REF_WIDTH),
        .CNT_W     (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick_cnt(tick_cnt),
        .line_end(line_end),
        .href    (href)
    );

    hdrv_osc_ctrl u_osc (
        .clk        (clk),
        .rst        (rst),
        .xtal_load  (xtal_load),
        .cal_req    (cal_req),
        .freq_ok    (freq_ok),
        .out_of_lock(out_of_lock),
        .freq_boost (freq_boost),
        .cal_busy   (cal_busy)
    );

    hdrv_guard u_guard (
        .clk       (clk),
        .rst       (rst),
        .stby_n    (stby_n),
        .ovp_trip  (ovp_trip),
        .resume_cmd(resume_cmd),
        .shut_q    (shut_q),
        .prot_flag (prot_flag)
    );

    // Trip and standby stop the drive on the very edge they are seen.
    assign drive_ok = !shut_q && stby_n && !ovp_trip && !freq_boost;

    hdrv_ramp #(
        .DUTY_START(DUTY_START),
        .DUTY_FINAL(DUTY_FINAL),
        .RAMP_LINES(RAMP_LINES),
        .CNT_W     (CNT_W)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .drive_ok(drive_ok),
        .line_end(line_end),
        .tick_cnt(tick_cnt),
        .run     (drive_on),
        .hdrv    (hdrv)
    );

endmodule

// File: rtl/hdrv_sequencer_chk.sv
module hdrv_sequencer_chk #(
    parameter int REF_WIDTH  = 32,
    parameter int DUTY_FINAL = 238
) (
    input logic clk,
    input logic rst,
    input logic out_of_lock,
    input logic stby_n,
    input logic ovp_trip,
    input logic resume_cmd,
    input logic hdrv,
    input logic href,
    input logic drive_on,
    input logic freq_boost,
    input logic cal_busy,
    input logic prot_flag
);

    int unsigned hi_run;
    int unsigned ref_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= 0;
            ref_run <= 0;
        end else begin
            hi_run  <= hdrv ? hi_run + 1 : 0;
            ref_run <= href ? ref_run + 1 : 0;
        end
    end

    a_r1_ref_width_cap: assert property (@(posedge clk) disable iff (rst)
        ref_run <= REF_WIDTH);

    a_r2_boost_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        freq_boost |-> !drive_on);

    a_r3_boost_exit_calibrates: assert property (@(posedge clk) disable iff (rst)
        $fell(freq_boost) |-> cal_busy);

    a_r4_unlock_recal: assert property (@(posedge clk) disable iff (rst)
        (out_of_lock && !freq_boost) |=> cal_busy);

    a_r5_trip_stops: assert property (@(posedge clk) disable iff (rst)
        ovp_trip |=> (!drive_on && !hdrv));

    a_r5_standby_stops: assert property (@(posedge clk) disable iff (rst)
        !stby_n |=> !drive_on);

    a_r6_trip_flags: assert property (@(posedge clk) disable iff (rst)
        ovp_trip |=> prot_flag);

    a_r6_prot_sticky: assert property (@(posedge clk) disable iff (rst)
        (prot_flag && !resume_cmd) |=> prot_flag);

    a_r7_pulse_needs_run: assert property (@(posedge clk) disable iff (rst)
        hdrv |-> drive_on);

    a_r8_width_cap: assert property (@(posedge clk) disable iff (rst)
        hi_run <= DUTY_FINAL);

endmodule

bind hdrv_sequencer hdrv_sequencer_chk #(
    .REF_WIDTH (REF_WIDTH),
    .DUTY_FINAL(DUTY_FINAL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_of_lock(out_of_lock),
    .stby_n     (stby_n),
    .ovp_trip   (ovp_trip),
    .resume_cmd (resume_cmd),
    .hdrv       (hdrv),
    .href       (href),
    .drive_on   (drive_on),
    .freq_boost (freq_boost),
    .cal_busy   (cal_busy),
    .prot_flag  (prot_flag)
);

// File: tb/test_hdrv_sequencer.sv
`timescale 1ns/1ps
module test_hdrv_sequencer;

    localparam int L  = 24;
    localparam int RW = 4;
    localparam int S  = 2;
    localparam int F  = 13;
    localparam int RL = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic xtal_load = 1'b0, cal_req = 1'b0, freq_ok = 1'b0, out_of_lock = 1'b0;
    logic stby_n = 1'b1, ovp_trip = 1'b0, resume_cmd = 1'b0;
    logic hdrv, href, drive_on, freq_boost, cal_busy, prot_flag;

    int checks = 0;
    int fails  = 0;
    int line_hi [64];
    bit line_ok [64];

    always #5 clk = ~clk;

    hdrv_sequencer #(
        .LINE_TICKS(L), .REF_WIDTH(RW), .DUTY_START(S),
        .DUTY_FINAL(F), .RAMP_LINES(RL)
    ) i_hdrv_sequencer (
        .clk(clk), .rst(rst), .xtal_load(xtal_load), .cal_req(cal_req),
        .freq_ok(freq_ok), .out_of_lock(out_of_lock), .stby_n(stby_n),
        .ovp_trip(ovp_trip), .resume_cmd(resume_cmd), .hdrv(hdrv),
        .href(href), .drive_on(drive_on), .freq_boost(freq_boost),
        .cal_busy(cal_busy), .prot_flag(prot_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_duty(input int j);
        int d;
        d = S + ((F - S) * j) / RL;
        return (d > F) ? F : d;
    endfunction

    task automatic to_line_start();
        logic prev;
        prev = href;
        @(negedge clk);
        while (!(href && !prev)) begin
            prev = href;
            @(negedge clk);
        end
    endtask

    // Measures n whole lines back to back; ends on tick 0 of the next line.
    task automatic measure_lines(input int n);
        to_line_start();
        for (int l = 0; l < n; l++) begin
            int  hi;
            bit  gap;
            bit  ok;
            hi = 0; gap = 0; ok = 1;
            for (int k = 0; k < L; k++) begin
                if (hdrv) begin
                    if (gap) ok = 0;
                    hi++;
                end else begin
                    gap = 1;
                end
                if (href != (k < RW)) ok = 0;
                @(negedge clk);
            end
            line_hi[l] = hi;
            line_ok[l] = ok;
        end
    endtask

    task automatic check_ramp(input string req, input int n);
        int f;
        measure_lines(n + 2);
        f = -1;
        for (int l = 0; l < n + 2; l++) if (f < 0 && line_hi[l] > 0) f = l;
        check({req, " ramp start found within two lines"}, int'(f >= 0 && f <= 1), 1);
        if (f >= 0 && f <= 1) begin
            for (int j = 0; j < n; j++) begin
                check({req, " duty per line"}, line_hi[f + j], exp_duty(j));
                check({req, " contiguous from tick 0"}, int'(line_ok[f + j]), 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        check("R2 hdrv", int'(hdrv), 0);
        check("R2 drive_on", int'(drive_on), 0);
        check("R2 freq_boost", int'(freq_boost), 1);
        check("R2 cal_busy", int'(cal_busy), 0);
        check("R2 prot_flag", int'(prot_flag), 0);

        // R1 reference pulse with drive off
        measure_lines(2);
        for (int l = 0; l < 2; l++) begin
            check("R1 href shape", int'(line_ok[l]), 1);
            check("R2 no drive while boosting", line_hi[l], 0);
        end

        // R4 out_of_lock ignored while boosting
        out_of_lock = 1'b1; @(negedge clk); out_of_lock = 1'b0;
        check("R4 unlock ignored in boost", int'(cal_busy), 0);

        // R3 calibration request before crystal load is ignored
        cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        check("R3 early cal_req boost", int'(freq_boost), 1);
        check("R3 early cal_req busy", int'(cal_busy), 0);

        // R2 resume accepted but boost still blocks drive
        resume_cmd = 1'b1; @(negedge clk); resume_cmd = 1'b0;
        measure_lines(2);
        check("R2 boost blocks after resume", line_hi[0] + line_hi[1], 0);

        // R3 proper order
        xtal_load = 1'b1; @(negedge clk); xtal_load = 1'b0;
        cal_req = 1'b1; @(negedge clk); cal_req = 1'b0;
        check("R3 boost dropped", int'(freq_boost), 0);
        check("R3 calibration busy", int'(cal_busy), 1);
        repeat (3) @(negedge clk);
        check("R4 busy holds without freq_ok", int'(cal_busy), 1);
        freq_ok = 1'b1; @(negedge clk); freq_ok = 1'b0;
        check("R4 busy cleared by freq_ok", int'(cal_busy), 0);

        // R7 R8 full ramp
        check_ramp("R7 R8", RL + 5);

        // R4 out_of_lock while running
        out_of_lock = 1'b1; @(negedge clk); out_of_lock = 1'b0;
        check("R4 recal on unlock", int'(cal_busy), 1);
        check("R4 drive keeps running", int'(drive_on), 1);
        freq_ok = 1'b1; @(negedge clk); freq_ok = 1'b0;
        check("R4 recal ends", int'(cal_busy), 0);

        // R5 R6 trip mid-pulse
        to_line_start();
        @(negedge clk);
        check("R5 pulse high before trip", int'(hdrv), 1);
        ovp_trip = 1'b1; @(negedge clk); ovp_trip = 1'b0;
        check("R5 hdrv off after trip", int'(hdrv), 0);
        check("R5 drive_on off after trip", int'(drive_on), 0);
        check("R6 prot set", int'(prot_flag), 1);
        measure_lines(2);
        check("R5 stays off after trip", line_hi[0] + line_hi[1], 0);

        // R6 trip and resume in the same cycle: trip wins
        ovp_trip = 1'b1; resume_cmd = 1'b1; @(negedge clk);
        ovp_trip = 1'b0; resume_cmd = 1'b0;
        check("R6 prot held on collision", int'(prot_flag), 1);
        measure_lines(1);
        check("R6 no drive after collision", line_hi[0], 0);

        // R6 R9 accepted resume restarts the ramp from the start value
        resume_cmd = 1'b1; @(negedge clk); resume_cmd = 1'b0;
        check("R6 prot cleared", int'(prot_flag), 0);
        check_ramp("R9 restart after trip", 6);

        // R5 standby; resume rejected during standby; raising stby_n alone does nothing
        stby_n = 1'b0; @(negedge clk);
        check("R5 standby stops drive", int'(drive_on), 0);
        check("R6 standby leaves prot clear", int'(prot_flag), 0);
        resume_cmd = 1'b1; @(negedge clk); resume_cmd = 1'b0;
        stby_n = 1'b1;
        measure_lines(2);
        check("R5 no restart without accepted resume", line_hi[0] + line_hi[1], 0);
        resume_cmd = 1'b1; @(negedge clk); resume_cmd = 1'b0;
        check_ramp("R9 restart after standby", 6);

        // R2 reset during run returns to boost
        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R2 reset re-boosts", int'(freq_boost), 1);
        check("R2 reset stops drive", int'(drive_on), 0);
        measure_lines(1);
        check("R1 href after reset", int'(line_ok[0]), 1);
        check("R2 no pulse after reset", line_hi[0], 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule